// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

This block is one 8-bit general-purpose I/O port sitting on a simple CPU register bus. Software reaches it through three registers. The direction register decides, pin by pin, whether the output driver is enabled. The output latch holds the values to drive. The pin register returns the levels seen at the pads, after a two-flop synchronizer. A write to the pin register lands in the output latch. The latch register can also be read back directly, so read-modify-write sequences work on stored values and not on whatever external loading does to the pads.

Pins can be claimed by other functions.

- A per-pin segment-drive enable takes a pin away from GPIO entirely.
- An oscillator-mode flag claims the two top pins. Those pins then read as zero in every register.
- Analog-select inputs apply to pins 0–3 and 5. They hide those pins from the pin register but leave the direction bit in control of the driver.

Pin 4 is open-drain: it can pull low or float, never drive high.

Top module: `gpio_port`

## Requirements
- R1: After reset the direction register reads 0xFF, the output latch reads 0x00, and every `pad_oe` bit is 0.
- R2: On an ordinary pin that nothing else claims, a direction bit of 0 sets `pad_oe` to 1 and drives the latch bit on `pad_out`. A direction bit of 1 clears `pad_oe`.
- R3: A write to address 0 (pin register) updates the output latch, which is readable at address 1. A write to address 1 updates the same latch. A write to address 2 updates the direction register, readable at address 2.
- R4: A read of address 0 returns `pad_in` as it stood two rising clock edges earlier. A pad change is not visible before the second edge.
- R5: A read of address 1 returns the stored latch value whatever the levels on `pad_in`.
- R6: While `osc_mode` is 1, bits 7 and 6 read as 0 at addresses 0, 1 and 2, and `pad_oe` and `pad_out` are 0 on those pins.
- R7: `pad_out[4]` is always 0. `pad_oe[4]` is 1 only when direction bit 4 is 0 and latch bit 4 is 0.
- R8: A pin whose `seg_en` bit is 1 has `pad_oe` and `pad_out` at 0, whatever its direction and latch bits hold.
- R9: An `ana_sel` bit at position 0, 1, 2, 3 or 5 makes that bit read 0 at address 0. It does not change `pad_oe`. `ana_sel` bits 4, 6 and 7 have no effect.
- R10: A write to address 3 changes no register, and a read of address 3 returns 0. `bus_rdata` is 0 whenever `bus_rd` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register select: 0 pin, 1 latch, 2 direction, 3 unused |
| bus_wr | input | 1 | Write strobe, acts on the rising edge |
| bus_rd | input | 1 | Read strobe, read data is combinational |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| osc_mode | input | 1 | Oscillator claims pins 7 and 6 |
| ana_sel | input | 8 | Analog select per pin, honoured on pins 0–3 and 5 |
| seg_en | input | 8 | Segment-drive claim per pin |
| pad_in | input | 8 | Levels at the pads |
| pad_oe | output | 8 | Per-pin output driver enable |
| pad_out | output | 8 | Per-pin output value |

## Verification
The pin-read latency check assumes that `pad_in`, `bus_rd`, `bus_addr`, `ana_sel` and `osc_mode` change only between clock edges. It also assumes that at least three edges have passed since reset, so that both synchronizer stages hold real pad samples. The bench drives every input one time unit after a rising edge. It holds `ana_sel` and `osc_mode` steady across the reads that depend on them. The claim checks on `pad_oe`/`pad_out` assume nothing about the bus, so the stimulus deliberately writes latch and direction values that would drive the claimed pins if the claims were ignored.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
   localparam int ADDR_W = 2;

   typedef enum logic [ADDR_W-1:0] {
      REG_PIN  = 2'd0,
      REG_LAT  = 2'd1,
      REG_DIR  = 2'd2,
      REG_NONE = 2'd3
   } gpio_reg_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] chain;

   generate
      if (STAGES < 1) begin : g_bad
         $error("gpio_sync: STAGES must be at least 1");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= '0;
               else        chain[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= '0;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
   import gpio_port_pkg::*;
#(
   parameter int           W       = 8,
   parameter logic [W-1:0] RST_DIR = '1,
   parameter logic [W-1:0] RST_LAT = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  gpio_reg_e    sel,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] lat_q,
   output logic [W-1:0] dir_q
);
   logic lat_we;
   logic dir_we;

   // pin-register writes are redirected into the output latch
   assign lat_we = wr && (sel == REG_PIN || sel == REG_LAT);
   assign dir_we = wr && (sel == REG_DIR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      lat_q <= RST_LAT;
      else if (lat_we) lat_q <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      dir_q <= RST_DIR;
      else if (dir_we) dir_q <= wdata;
   end
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
   parameter int W      = 8,
   parameter int OD_PIN = 4,
   parameter int OSC_LO = 6,
   parameter int OSC_HI = 7
) (
   input  logic [W-1:0] dir_q,
   input  logic [W-1:0] lat_q,
   input  logic [W-1:0] seg_en,
   input  logic         osc_mode,
   output logic [W-1:0] oe,
   output logic [W-1:0] dout
);
   generate
      for (genvar i = 0; i < W; i++) begin : g_pin
         localparam bit IS_OSC = (i == OSC_LO) || (i == OSC_HI);
         logic claimed;
         assign claimed = seg_en[i] | (IS_OSC & osc_mode);

         if (i == OD_PIN) begin : g_od
            // open drain: enable the driver only to pull low
            assign oe[i]   = ~claimed & ~dir_q[i] & ~lat_q[i];
            assign dout[i] = 1'b0;
         end else begin : g_pp
            assign oe[i]   = ~claimed & ~dir_q[i];
            assign dout[i] = ~claimed & lat_q[i];
         end
      end
   endgenerate
endmodule

// File: rtl/gpio_rd_mux.sv
module gpio_rd_mux
   import gpio_port_pkg::*;
#(
   parameter int           W        = 8,
   parameter int           OSC_LO   = 6,
   parameter int           OSC_HI   = 7,
   parameter logic [W-1:0] ANA_MASK = 8'h2F
) (
   input  logic         rd,
   input  gpio_reg_e    sel,
   input  logic [W-1:0] pin_s,
   input  logic [W-1:0] lat_q,
   input  logic [W-1:0] dir_q,
   input  logic         osc_mode,
   input  logic [W-1:0] ana_sel,
   output logic [W-1:0] rdata
);
   logic [W-1:0] osc_bits;
   logic [W-1:0] vis;
   logic [W-1:0] pin_vis;

   generate
      for (genvar i = 0; i < W; i++) begin : g_osc
         assign osc_bits[i] = (i == OSC_LO) || (i == OSC_HI);
      end
   endgenerate

   assign vis     = osc_mode ? ~osc_bits : '1;
   assign pin_vis = vis & ~(ana_sel & ANA_MASK);

   always_comb begin
      rdata = '0;
      if (rd) begin
         unique case (sel)
            REG_PIN:  rdata = pin_s & pin_vis;
            REG_LAT:  rdata = lat_q & vis;
            REG_DIR:  rdata = dir_q & vis;
            default:  rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
   import gpio_port_pkg::*;
#(
   parameter int           WIDTH       = 8,
   parameter int           SYNC_STAGES = 2,
   parameter int           OD_PIN      = 4,
   parameter int           OSC_LO      = 6,
   parameter int           OSC_HI      = 7,
   parameter logic [WIDTH-1:0] ANA_MASK = 8'h2F
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       bus_addr,
   input  logic             bus_wr,
   input  logic             bus_rd,
   input  logic [WIDTH-1:0] bus_wdata,
   output logic [WIDTH-1:0] bus_rdata,
   input  logic             osc_mode,
   input  logic [WIDTH-1:0] ana_sel,
   input  logic [WIDTH-1:0] seg_en,
   input  logic [WIDTH-1:0] pad_in,
   output logic [WIDTH-1:0] pad_oe,
   output logic [WIDTH-1:0] pad_out
);
   generate
      if (OD_PIN >= WIDTH || OSC_LO >= WIDTH || OSC_HI >= WIDTH) begin : g_bad_pin
         $error("gpio_port: special pin index outside the port");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("gpio_port: at least two synchronizer stages are required");
      end
   endgenerate

   gpio_reg_e        sel;
   logic [WIDTH-1:0] lat_q;
   logic [WIDTH-1:0] dir_q;
   logic [WIDTH-1:0] pin_s;

   assign sel = gpio_reg_e'(bus_addr);

   gpio_regs #(.W(WIDTH)) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (bus_wr),
      .sel   (sel),
      .wdata (bus_wdata),
      .lat_q (lat_q),
      .dir_q (dir_q)
   );

   gpio_sync #(.W(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (pin_s)
   );

   gpio_pad_ctrl #(.W(WIDTH), .OD_PIN(OD_PIN), .OSC_LO(OSC_LO), .OSC_HI(OSC_HI)) u_pads (
      .dir_q    (dir_q),
      .lat_q    (lat_q),
      .seg_en   (seg_en),
      .osc_mode (osc_mode),
      .oe       (pad_oe),
      .dout     (pad_out)
   );

   gpio_rd_mux #(.W(WIDTH), .OSC_LO(OSC_LO), .OSC_HI(OSC_HI), .ANA_MASK(ANA_MASK)) u_rd (
      .rd       (bus_rd),
      .sel      (sel),
      .pin_s    (pin_s),
      .lat_q    (lat_q),
      .dir_q    (dir_q),
      .osc_mode (osc_mode),
      .ana_sel  (ana_sel),
      .rdata    (bus_rdata)
   );
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
   parameter int WIDTH  = 8,
   parameter int OD_PIN = 4,
   parameter int OSC_LO = 6,
   parameter int OSC_HI = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       bus_addr,
   input logic             bus_rd,
   input logic [WIDTH-1:0] bus_rdata,
   input logic             osc_mode,
   input logic [WIDTH-1:0] ana_sel,
   input logic [WIDTH-1:0] seg_en,
   input logic [WIDTH-1:0] pad_in,
   input logic [WIDTH-1:0] pad_oe,
   input logic [WIDTH-1:0] pad_out
);
   logic [1:0] since_rst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 since_rst <= '0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
   end

   // R7
   od_never_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pad_out[OD_PIN] == 1'b0);

   // R8
   seg_blocks_gpio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((seg_en & pad_oe) == '0) && ((seg_en & pad_out) == '0));

   // R6
   osc_pins_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
      osc_mode |-> (!pad_oe[OSC_LO] && !pad_oe[OSC_HI] && !pad_out[OSC_LO] && !pad_out[OSC_HI]));

   // R4
   pin_read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst == 2'd3 && bus_rd && bus_addr == 2'd0 && !osc_mode && ana_sel == '0)
         |-> bus_rdata == $past(pad_in, 2));

   // R10
   idle_rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |-> bus_rdata == '0);

   // R10
   hole_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == 2'd3) |-> bus_rdata == '0);
endmodule

bind gpio_port gpio_port_chk #(
   .WIDTH(WIDTH), .OD_PIN(OD_PIN), .OSC_LO(OSC_LO), .OSC_HI(OSC_HI)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_rd    (bus_rd),
   .bus_rdata (bus_rdata),
   .osc_mode  (osc_mode),
   .ana_sel   (ana_sel),
   .seg_en    (seg_en),
   .pad_in    (pad_in),
   .pad_oe    (pad_oe),
   .pad_out   (pad_out)
);

// File: tb/gpio_port_test.sv
`timescale 1ns/1ps
module gpio_port_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] bus_addr = '0;
   logic       bus_wr = 1'b0;
   logic       bus_rd = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       osc_mode = 1'b0;
   logic [7:0] ana_sel = '0;
   logic [7:0] seg_en = '0;
   logic [7:0] pad_in = '0;
   logic [7:0] pad_oe;
   logic [7:0] pad_out;

   int  n_tests = 0;
   int  n_fail  = 0;
   bit  done    = 1'b0;

   typedef struct {
      logic [7:0] exp;
      string      tag;
   } rd_item_t;
   rd_item_t sb[$];

   always #5 clk = ~clk;

   gpio_port uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .osc_mode(osc_mode), .ana_sel(ana_sel), .seg_en(seg_en),
      .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out)
   );

   // monitor: pops the expected value for every read cycle
   always @(negedge clk) begin
      if (bus_rd) begin
         n_tests++;
         if (sb.size() == 0) begin
            n_fail++;
            $display("FAIL read with no expectation: actual %h expected none", bus_rdata);
         end else begin
            rd_item_t it;
            it = sb.pop_front();
            if (bus_rdata !== it.exp) begin
               n_fail++;
               $display("FAIL %s: rdata actual %h expected %h", it.tag, bus_rdata, it.exp);
            end
         end
      end
   end

   // all tasks start and end one time unit after a rising edge
   task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk); #1;
      bus_wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [1:0] a, input logic [7:0] exp, input string tag);
      rd_item_t it;
      it.exp = exp; it.tag = tag;
      sb.push_back(it);
      bus_addr = a; bus_rd = 1'b1;
      @(posedge clk); #1;
      bus_rd = 1'b0;
   endtask

   task automatic chk_pads(input logic [7:0] eoe, input logic [7:0] eout, input string tag);
      n_tests++;
      if (pad_oe !== eoe || pad_out !== eout) begin
         n_fail++;
         $display("FAIL %s: oe/out actual %h/%h expected %h/%h", tag, pad_oe, pad_out, eoe, eout);
      end
   endtask

   task automatic chk_idle(input string tag);
      n_tests++;
      if (bus_rdata !== 8'h00) begin
         n_fail++;
         $display("FAIL %s: idle rdata actual %h expected 00", tag, bus_rdata);
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      pad_in = 8'h3C;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk); #1;

      // R1 reset state
      chk_pads(8'h00, 8'h00, "R1 pads after reset");
      rd_reg(2'd2, 8'hFF, "R1 dir reset");
      rd_reg(2'd1, 8'h00, "R1 latch reset");
      chk_idle("R10 no read strobe");

      // R3 pin write lands in latch; R5 latch read ignores pads
      wr_reg(2'd0, 8'hA5);
      rd_reg(2'd1, 8'hA5, "R3 pin write to latch");
      rd_reg(2'd1, 8'hA5, "R5 latch independent of pad_in 3C");
      wr_reg(2'd2, 8'h00);
      rd_reg(2'd2, 8'h00, "R3 dir write");
      chk_pads(8'hFF, 8'hA5, "R2 all outputs latch A5");

      // R7 open drain with latch bit 4 high
      wr_reg(2'd1, 8'hFF);
      chk_pads(8'hEF, 8'hEF, "R7 od pin floats on high");
      wr_reg(2'd2, 8'hF0);
      chk_pads(8'h0F, 8'hEF, "R2 upper inputs");

      // R4 synchronizer latency
      pad_in = 8'h5A;
      rd_reg(2'd0, 8'h3C, "R4 zero edges");
      rd_reg(2'd0, 8'h3C, "R4 one edge");
      rd_reg(2'd0, 8'h5A, "R4 two edges");

      // R8 segment claim
      wr_reg(2'd2, 8'h00);
      seg_en = 8'h03; #1;
      chk_pads(8'hEC, 8'hEC, "R8 seg pins 0 1");
      seg_en = 8'h00; #1;

      // R6 oscillator claim
      pad_in = 8'hFF;
      repeat (2) @(posedge clk); #1;
      osc_mode = 1'b1; #1;
      chk_pads(8'h2F, 8'h2F, "R6 osc pads");
      rd_reg(2'd0, 8'h3F, "R6 pin read");
      rd_reg(2'd1, 8'h3F, "R6 latch read");
      rd_reg(2'd2, 8'h00, "R6 dir read");
      osc_mode = 1'b0; #1;

      // R9 analog select
      ana_sel = 8'hFF; #1;
      rd_reg(2'd0, 8'hD0, "R9 analog hides pins");
      chk_pads(8'hEF, 8'hEF, "R9 dir still drives");
      ana_sel = 8'hD0; #1;
      rd_reg(2'd0, 8'hFF, "R9 unmasked bits ignored");
      ana_sel = 8'h00; #1;

      // R10 unused address
      wr_reg(2'd3, 8'h55);
      rd_reg(2'd3, 8'h00, "R10 hole read");
      rd_reg(2'd1, 8'hFF, "R10 latch unchanged");
      rd_reg(2'd2, 8'h00, "R10 dir unchanged");
      chk_idle("R10 idle after reads");

      // R7 low drive on od pin
      wr_reg(2'd1, 8'h00);
      chk_pads(8'hFF, 8'h00, "R7 od pin pulls low");

      @(posedge clk); #1;
      if (sb.size() != 0) begin
         n_tests++; n_fail++;
         $display("FAIL scoreboard: actual %0d left expected 0", sb.size());
      end
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule